// File: doc/BRIEF.md
# Early/Late Strobe Delay Adaptor

This block keeps a receiver's sampling strobe centred on the data eye. A phase detector reports, on each recovered clock, whether the strobe looked early, late, both or neither. The adaptor counts both kinds of indication over a window of clocks. At the end of each window it publishes the two counts. If the imbalance clears the selected threshold rule, it moves a signed delay code one step toward the correct position.

Four threshold rules are available:
- a fixed imbalance threshold;
- a dominance ratio of at least sixty percent;
- two hysteretic rules that compare the imbalance with the size of the last step taken the other way.

Adaption is gated by a master enable and by a start condition. The start condition is frequency lock, or equalizer search completion, or an override that allows adaption at all times. A measure-only setting keeps the counts flowing but freezes the code. The analog delay line that consumes the code lies outside the block.

Top module: `strobe_adapt`

## Requirements
- R1: After reset the delay code is 0 and both published counts are 0.
- R2: A window lasts 2^(BASE_LOG2+smplSize) clocks, where smplSize is the 2-bit window-size input. With the default BASE_LOG2 = 8 this gives 256, 512, 1024 or 2048 clocks. The counts of a window, including its final clock, appear on earlyCount/lateCount in the cycle after that final clock. They are unchanged before then.
- R3: If a window ends with more early than late indications, the code rises by one. If it ends with more late than early, the code falls by one. If the counts are equal, the code does not move. The code moves at most one step per window.
- R4: The delay code saturates at +7 and -7 and never reaches -8.
- R5: With thrMode = 00, a step is taken only when |early - late| is strictly greater than the thrValue input. A thrValue of 0 means any imbalance steps.
- R6: With thrMode = 01, a step is taken only when the dominant count times 5 is at least 3 times the sum of early and late.
- R7: For the two hysteretic rules, the imbalance is compared with the stored magnitude of the last step taken in the opposite direction. With thrMode = 10 a step is taken when 2·imbalance ≥ that magnitude. With thrMode = 11 a step is taken when imbalance ≥ that magnitude. Each step that is taken stores its own imbalance as the magnitude for its direction, even when the code is already saturated.
- R8: Adaption is active when the enable input is 1 and a start condition holds. The start condition is alwaysOn = 1; or adaptMode = 0 with freqLock = 1; or adaptMode = 1 with eqDone = 1. alwaysOn overrides adaptMode. While adaption is inactive, nothing is counted, and the code and the published counts hold.
- R9: With enable = 0 adaption is inactive, even when alwaysOn is 1.
- R10: With measOnly = 1, windows still complete and publish their counts, but the code does not move and no step magnitude is stored.
- R11: Both stored step magnitudes are cleared to 0 on any cycle in which adaption is inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master enable for dynamic adaption |
| alwaysOn | input | 1 | Allow adaption regardless of lock status |
| adaptMode | input | 1 | 0: start on frequency lock, 1: start on equalizer done |
| measOnly | input | 1 | Count and publish, but freeze the code |
| thrMode | input | 2 | Threshold rule select (00 fixed, 01 ratio, 10 half hysteresis, 11 full hysteresis) |
| smplSize | input | 2 | Window size select |
| thrValue | input | BASE_LOG2+4 | Fixed imbalance threshold for rule 00 |
| freqLock | input | 1 | Clock recovery frequency lock |
| eqDone | input | 1 | Equalizer search complete |
| earlyIn | input | 1 | Early indication for this clock |
| lateIn | input | 1 | Late indication for this clock |
| delayCode | output | 4 | Signed strobe delay code |
| earlyCount | output | BASE_LOG2+4 | Early count of the last completed window |
| lateCount | output | BASE_LOG2+4 | Late count of the last completed window |

## Verification
The assertions need only known values on the inputs. They allow the control fields to change on any cycle, because they check only properties that hold at every edge: the code range, single steps, the freeze under measure-only, and the hold while disabled. The bench changes window size, threshold rule, gating and measure-only only between windows. This keeps the window boundaries of its arithmetic model aligned with the design's window counter. It sweeps imbalances densely on the smallest window so that every threshold comparison is exercised on both sides of its edge.

// File: rtl/strobe_adapt_pkg.sv
package strobe_adapt_pkg;

  // Strobes from window control to the datapath
  typedef struct packed {
    logic clear;   // adaption inactive: drop partial counts and step memory
    logic count;   // accumulate this clock's indications
    logic close;   // this clock ends the window
  } winCtrl_t;

  typedef enum logic [1:0] {
    THR_FIXED = 2'b00,
    THR_RATIO = 2'b01,
    THR_HALF  = 2'b10,
    THR_FULL  = 2'b11
  } thrMode_t;

endpackage

// File: rtl/strobe_adapt_ctrl.sv
module strobe_adapt_ctrl
  import strobe_adapt_pkg::*;
#(
  parameter int BASE_LOG2 = 8,
  parameter int CNT_W     = BASE_LOG2 + 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       alwaysOn,
  input  logic       adaptMode,
  input  logic       freqLock,
  input  logic       eqDone,
  input  logic [1:0] smplSize,
  output winCtrl_t   ctl
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             startOk;
  logic             active;

  always_comb begin
    startOk   = alwaysOn | (adaptMode ? eqDone : freqLock);
    active    = enable & startOk;
    lastIdx   = (ONE << (BASE_LOG2 + 32'(smplSize))) - ONE;
    ctl.clear = ~active;
    ctl.count = active;
    ctl.close = active & (winCnt >= lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      winCnt <= '0;
    else if (!active || ctl.close)   winCnt <= '0;
    else                             winCnt <= winCnt + ONE;
  end

endmodule

// File: rtl/strobe_adapt_dp.sv
module strobe_adapt_dp
  import strobe_adapt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  winCtrl_t                 ctl,
  input  logic                     earlyIn,
  input  logic                     lateIn,
  input  logic                     measOnly,
  input  logic [1:0]               thrMode,
  input  logic [CNT_W-1:0]         thrValue,
  output logic signed [CODE_W-1:0] delayCode,
  output logic [CNT_W-1:0]         earlyCount,
  output logic [CNT_W-1:0]         lateCount
);

  localparam int WW = CNT_W + 4;
  localparam logic signed [CODE_W-1:0] CODE_HI = {1'b0, {(CODE_W-1){1'b1}}};
  localparam logic signed [CODE_W-1:0] CODE_LO = -CODE_HI;

  logic [CNT_W-1:0] earlyAcc, lateAcc;
  logic [CNT_W-1:0] eSum, lSum, mag, dom, prevOpp;
  logic [CNT_W:0]   total;
  logic [WW-1:0]    domX5, totX3;
  logic             up, dn, pass, stepUp, stepDn;

  // Per-direction step magnitudes: index 1 = up (early), 0 = down (late)
  logic [CNT_W-1:0] lastMag [2];

  always_comb begin
    eSum    = earlyAcc + CNT_W'(earlyIn);
    lSum    = lateAcc + CNT_W'(lateIn);
    up      = eSum > lSum;
    dn      = lSum > eSum;
    mag     = up ? (eSum - lSum) : (lSum - eSum);
    dom     = up ? eSum : lSum;
    total   = {1'b0, eSum} + {1'b0, lSum};
    domX5   = WW'(dom) * WW'(5);
    totX3   = WW'(total) * WW'(3);
    prevOpp = up ? lastMag[0] : lastMag[1];
    case (thrMode_t'(thrMode))
      THR_FIXED: pass = mag > thrValue;
      THR_RATIO: pass = domX5 >= totX3;
      THR_HALF:  pass = {mag, 1'b0} >= {1'b0, prevOpp};
      THR_FULL:  pass = mag >= prevOpp;
      default:   pass = 1'b0;
    endcase
    stepUp = ctl.close & up & pass & ~measOnly;
    stepDn = ctl.close & dn & pass & ~measOnly;
  end

  // Window accumulators and published counts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      earlyAcc   <= '0;
      lateAcc    <= '0;
      earlyCount <= '0;
      lateCount  <= '0;
    end else if (ctl.clear || ctl.close) begin
      earlyAcc <= '0;
      lateAcc  <= '0;
      if (ctl.close) begin
        earlyCount <= eSum;
        lateCount  <= lSum;
      end
    end else if (ctl.count) begin
      earlyAcc <= eSum;
      lateAcc  <= lSum;
    end
  end

  // Step memories, one per direction
  for (genvar d = 0; d < 2; d++) begin : g_mem
    logic take;
    assign take = (d == 1) ? stepUp : stepDn;
    always_ff @(posedge clk) begin
      if (!rst_n || ctl.clear) lastMag[d] <= '0;
      else if (take)           lastMag[d] <= mag;
    end
  end

  // Saturating delay code
  always_ff @(posedge clk) begin
    if (!rst_n)                             delayCode <= '0;
    else if (stepUp && delayCode != CODE_HI) delayCode <= delayCode + CODE_W'(1);
    else if (stepDn && delayCode != CODE_LO) delayCode <= delayCode - CODE_W'(1);
  end

endmodule

// File: rtl/strobe_adapt.sv
module strobe_adapt
  import strobe_adapt_pkg::*;
#(
  parameter  int BASE_LOG2 = 8,
  localparam int CNT_W     = BASE_LOG2 + 4,
  localparam int CODE_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     alwaysOn,
  input  logic                     adaptMode,
  input  logic                     measOnly,
  input  logic [1:0]               thrMode,
  input  logic [1:0]               smplSize,
  input  logic [CNT_W-1:0]         thrValue,
  input  logic                     freqLock,
  input  logic                     eqDone,
  input  logic                     earlyIn,
  input  logic                     lateIn,
  output logic signed [CODE_W-1:0] delayCode,
  output logic [CNT_W-1:0]         earlyCount,
  output logic [CNT_W-1:0]         lateCount
);

  winCtrl_t ctl;

  strobe_adapt_ctrl #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .alwaysOn(alwaysOn),
    .adaptMode(adaptMode), .freqLock(freqLock), .eqDone(eqDone),
    .smplSize(smplSize), .ctl(ctl)
  );

  strobe_adapt_dp #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .earlyIn(earlyIn), .lateIn(lateIn),
    .measOnly(measOnly), .thrMode(thrMode), .thrValue(thrValue),
    .delayCode(delayCode), .earlyCount(earlyCount), .lateCount(lateCount)
  );

endmodule

// File: rtl/strobe_adapt_checker.sv
module strobe_adapt_checker #(
  parameter int BASE_LOG2 = 8,
  parameter int CNT_W     = BASE_LOG2 + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              measOnly,
  input logic signed [3:0] delayCode,
  input logic [CNT_W-1:0]  earlyCount,
  input logic [CNT_W-1:0]  lateCount
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << (BASE_LOG2 + 3);

  // R4: code stays within the symmetric range
  assert_code_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (delayCode >= -4'sd7) && (delayCode <= 4'sd7));

  // R3: at most one step per cycle
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(delayCode) - int'($past(delayCode))) inside {-1, 0, 1}));

  // R10: measure-only freezes the code
  assert_meas_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    measOnly |=> $stable(delayCode));

  // R9: disabled block holds code and published counts
  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(delayCode) && $stable(earlyCount) && $stable(lateCount)));

  // R2: published counts never exceed the largest window
  assert_count_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (earlyCount <= MAX_CNT) && (lateCount <= MAX_CNT));

endmodule

bind strobe_adapt strobe_adapt_checker #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .measOnly(measOnly),
  .delayCode(delayCode), .earlyCount(earlyCount), .lateCount(lateCount)
);

// File: tb/strobe_adapt_tb.sv
module strobe_adapt_tb;

  localparam int BASE = 4;
  localparam int CW   = BASE + 4;

  logic clk = 1'b0;
  logic rst_n, enable, alwaysOn, adaptMode, measOnly, freqLock, eqDone, earlyIn, lateIn;
  logic [1:0] thrMode, smplSize;
  logic [CW-1:0] thrValue;
  logic signed [3:0] delayCode;
  logic [CW-1:0] earlyCount, lateCount;

  always #4 clk = ~clk;

  strobe_adapt #(.BASE_LOG2(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .alwaysOn(alwaysOn),
    .adaptMode(adaptMode), .measOnly(measOnly), .thrMode(thrMode),
    .smplSize(smplSize), .thrValue(thrValue), .freqLock(freqLock),
    .eqDone(eqDone), .earlyIn(earlyIn), .lateIn(lateIn),
    .delayCode(delayCode), .earlyCount(earlyCount), .lateCount(lateCount)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int expCode = 0, expE = 0, expL = 0, memUp = 0, memDn = 0;

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit isActive();
    return enable && (alwaysOn || (adaptMode ? eqDone : freqLock));
  endfunction

  // Model one window: e early flags at its start, l late flags at its end
  task automatic runWindow(int e, int l, string tag);
    int n = 1 << (BASE + int'(smplSize));
    bit act = isActive();
    for (int i = 0; i < n; i++) begin
      earlyIn = (i < e);
      lateIn  = (i >= n - l);
      @(negedge clk);
      if (i == n - 2) begin
        chk(int'(earlyCount), expE, {tag, " R2 early before close"});
        chk(int'(lateCount),  expL, {tag, " R2 late before close"});
      end
    end
    earlyIn = 0; lateIn = 0;
    if (!act) begin
      memUp = 0; memDn = 0;   // R11
    end else begin
      int mag, dom, prev;
      bit upDir, pass;
      expE = e; expL = l;
      if (e != l) begin
        upDir = e > l;
        mag   = upDir ? e - l : l - e;
        dom   = upDir ? e : l;
        prev  = upDir ? memDn : memUp;
        case (thrMode)
          2'b00: pass = mag > int'(thrValue);
          2'b01: pass = dom * 5 >= (e + l) * 3;
          2'b10: pass = 2 * mag >= prev;
          default: pass = mag >= prev;
        endcase
        if (pass && !measOnly) begin
          if (upDir) begin
            memUp = mag; if (expCode < 7) expCode++;
          end else begin
            memDn = mag; if (expCode > -7) expCode--;
          end
        end
      end
    end
    chk(int'(earlyCount), expE, {tag, " early count"});
    chk(int'(lateCount),  expL, {tag, " late count"});
    chk(int'(delayCode),  expCode, {tag, " code"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; alwaysOn = 0; adaptMode = 0; measOnly = 0;
    thrMode = 2'b00; smplSize = 2'b00; thrValue = '0; freqLock = 0; eqDone = 0;
    earlyIn = 0; lateIn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(int'(delayCode), 0, "R1 reset code");
    chk(int'(earlyCount), 0, "R1 reset early");
    chk(int'(lateCount), 0, "R1 reset late");

    enable = 1; freqLock = 1;
    // R2: every window size, all-early then all-late
    for (int s = 0; s < 4; s++) begin
      int n = 1 << (BASE + s);
      smplSize = 2'(s);
      runWindow(n, 0, "R2 R3 up");
      runWindow(1, n, "R2 R3 down");
    end
    smplSize = 2'b00;
    runWindow(5, 5, "R3 balanced");
    runWindow(16, 16, "R3 balanced full");

    // R5: fixed threshold sweep
    for (int t = 0; t < 8; t += 3) begin
      thrValue = CW'(t);
      for (int d = 0; d <= 8; d++) begin
        runWindow(4 + d, 4, "R5 fixed up");
        runWindow(4, 4 + d, "R5 fixed down");
      end
    end
    thrValue = '0;

    // R4: saturation both ways
    for (int k = 0; k < 10; k++) runWindow(16, 0, "R4 saturate high");
    for (int k = 0; k < 16; k++) runWindow(0, 16, "R4 saturate low");

    // R6: ratio rule sweep
    thrMode = 2'b01;
    for (int e = 0; e <= 16; e++) runWindow(e, 16 - e, "R6 ratio");
    for (int e = 0; e <= 12; e++) runWindow(e, 4, "R6 ratio skew");

    // R7: hysteretic rules
    for (int m = 2; m <= 3; m++) begin
      thrMode = 2'(m);
      for (int a = 1; a <= 8; a++)
        for (int b = 1; b <= 8; b += 3) begin
          runWindow(4 + a, 4, "R7 hyst up");
          runWindow(4, 4 + b, "R7 hyst down");
        end
    end

    // R10: measure-only
    thrMode = 2'b00;
    measOnly = 1;
    runWindow(16, 0, "R10 meas up");
    runWindow(0, 16, "R10 meas down");
    measOnly = 0;

    // R8: start conditions
    freqLock = 0;
    runWindow(16, 0, "R8 no lock");
    adaptMode = 1; freqLock = 1; eqDone = 0;
    runWindow(0, 16, "R8 eq not done");
    eqDone = 1;
    runWindow(0, 16, "R8 eq done");
    adaptMode = 0; freqLock = 0; eqDone = 0; alwaysOn = 1;
    runWindow(16, 2, "R8 always on");

    // R9: master enable overrides alwaysOn
    enable = 0;
    runWindow(0, 16, "R9 disabled");
    enable = 1;

    // R11: memory cleared while inactive
    thrMode = 2'b11;
    runWindow(0, 12, "R11 big down");
    runWindow(5, 4, "R11 small up blocked");
    alwaysOn = 0;
    runWindow(5, 4, "R11 inactive");
    alwaysOn = 1;
    runWindow(5, 4, "R11 small up after clear");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule